// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block rebuilds characters from an asynchronous serial line. It runs on a receive clock at a fixed multiple of the bit rate, 16 by default. A falling edge on the idle-high line starts a candidate frame. The line is checked again half a bit later to confirm a real start bit. After that, every later bit is sampled at its centre. The data bits are assembled in order, an optional parity bit is checked, and then the stop bit is checked.

When the stop bit has been sampled, the character is copied into an output holding register and a ready flag is raised. Three error flags are refreshed together with that copy: one for a lost character, one for a bad stop bit and one for a parity mismatch. The host reads the character and then pulses a clear input to drop the ready flag. The character length and parity options are sampled when a start bit is confirmed, so they may change between frames. A synchronous master reset returns the block to idle with every flag clear.

Top module: `async_char_rx`

## Requirements
- R1: `len_sel` selects the character length, latched at start-bit confirmation: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. In `rx_data`, every bit at or above the character length reads 0.
- R2: The first data bit on the line lands in `rx_data[0]`, and each later bit lands at the next higher position.
- R3: When `parity_off` is 0, one parity bit follows the data. With `parity_even`=1, the data bits plus the parity bit must hold an even number of ones. With `parity_even`=0 they must hold an odd number. On a mismatch, `parity_err` is set to 1 when the character is transferred.
- R4: When `parity_off` is 1, the stop bit directly follows the data and `parity_err` is 0 after the transfer.
- R5: A stop bit sampled as 0 sets `framing_err` to 1 when the character is transferred. A stop bit sampled as 1 sets it to 0.
- R6: On the clock edge that samples the stop bit, the character is written into `rx_data` and `data_ready` becomes 1.
- R7: A one-cycle pulse on `clr_ready` with no transfer on the same edge drops `data_ready` to 0 and leaves `rx_data` unchanged.
- R8: If a character is transferred while `data_ready` is still 1 and `clr_ready` is not asserted, `overrun_err` becomes 1. The new character replaces the old one.
- R9: A falling edge on the line followed by a high level at the start-bit centre (OVERSAMPLE/2 clocks later) is ignored. No transfer takes place.
- R10: While `rst` is 1, `data_ready` and all error flags are 0 and `rx_data` is 0. Reset also abandons a partly received frame.
- R11: A falling edge on the line in the cycle right after the stop-bit sample starts a new frame, which is received correctly.
- R12: All three error flags are rewritten on every transfer. They keep their value between transfers, so a good character clears a flag left by an earlier bad one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock at OVERSAMPLE times the bit rate |
| rst | input | 1 | Synchronous master reset, active high |
| rx_line | input | 1 | Serial input, idle high |
| len_sel | input | 2 | Character length code (00=5 .. 11=8 bits) |
| parity_off | input | 1 | 1: no parity bit in the frame |
| parity_even | input | 1 | 1: even parity, 0: odd parity |
| clr_ready | input | 1 | Host strobe that clears data_ready |
| rx_data | output | 8 | Last received character, zero-extended |
| data_ready | output | 1 | A character is waiting for the host |
| overrun_err | output | 1 | Previous character was not collected in time |
| framing_err | output | 1 | Stop bit was sampled low |
| parity_err | output | 1 | Parity bit did not match the selected sense |

## Verification
The bench first checks each length code against data whose upper bits are set, so a receiver that skips zero-extension or shifts the bits the wrong way shows wrong high bits. Both parity senses are tested with a good parity bit and with a flipped one, and a parity-off frame carries no parity bit at all; a receiver that always expects a parity bit would then take the stop bit as parity and flag an error. A glitch that returns high before mid-start must produce no character, and a frame that starts in the cycle right after the previous stop sample must arrive intact; a receiver that waits out a whole stop bit would miss that edge. Flags are checked for being set and for being overwritten by the next good character, and a reset in mid-frame must clear everything.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

   localparam int CHAR_MAX = 8;
   localparam int IDX_W    = $clog2(CHAR_MAX);

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_START,
      PH_DATA,
      PH_PAR,
      PH_STOP
   } rx_phase_t;

   // 2-bit length code to bit count: 00->5 .. 11->8
   function automatic logic [3:0] char_bits(input logic [1:0] code);
      return 4'd5 + {2'b00, code};
   endfunction

endpackage

// File: rtl/rx_bit_timer.sv
module rx_bit_timer
   import async_rx_pkg::*;
#(
   parameter int OVERSAMPLE = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             rx_line,
   input  logic [1:0]       len_sel,
   input  logic             parity_off,
   input  logic             parity_even,
   output logic             frame_start,
   output logic             sample_data,
   output logic             sample_par,
   output logic             sample_stop,
   output logic [IDX_W-1:0] bit_idx,
   output logic [1:0]       len_q,
   output logic             poff_q,
   output logic             even_q
);

   localparam int CNT_W = $clog2(OVERSAMPLE);
   localparam int HALF  = OVERSAMPLE / 2;

   generate
      if ((OVERSAMPLE < 4) || ((OVERSAMPLE % 2) != 0)) begin : g_bad_oversample
         initial $fatal(1, "rx_bit_timer: OVERSAMPLE must be even and at least 4");
      end
   endgenerate

   rx_phase_t        phase;
   logic [CNT_W-1:0] cnt;
   logic             line_q;
   logic             tick;
   logic             mid_start;
   logic [3:0]       last_idx;

   assign tick      = (cnt == CNT_W'(OVERSAMPLE - 1));
   assign mid_start = (phase == PH_START) && (cnt == CNT_W'(HALF - 1));
   assign last_idx  = char_bits(len_q) - 4'd1;

   assign frame_start = mid_start && !rx_line;
   assign sample_data = (phase == PH_DATA) && tick;
   assign sample_par  = (phase == PH_PAR)  && tick;
   assign sample_stop = (phase == PH_STOP) && tick;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase   <= PH_IDLE;
         cnt     <= '0;
         line_q  <= 1'b1;
         bit_idx <= '0;
         len_q   <= 2'b11;
         poff_q  <= 1'b0;
         even_q  <= 1'b0;
      end else begin
         line_q <= rx_line;
         case (phase)
            PH_IDLE: begin
               cnt <= '0;
               if (line_q && !rx_line) phase <= PH_START;
            end
            PH_START: begin
               if (mid_start) begin
                  cnt     <= '0;
                  bit_idx <= '0;
                  if (!rx_line) begin
                     phase  <= PH_DATA;
                     len_q  <= len_sel;
                     poff_q <= parity_off;
                     even_q <= parity_even;
                  end else begin
                     phase <= PH_IDLE;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PH_DATA: begin
               cnt <= cnt + 1'b1;
               if (tick) begin
                  if ({1'b0, bit_idx} == last_idx) phase <= poff_q ? PH_STOP : PH_PAR;
                  else bit_idx <= bit_idx + 1'b1;
               end
            end
            PH_PAR: begin
               cnt <= cnt + 1'b1;
               if (tick) phase <= PH_STOP;
            end
            PH_STOP: begin
               cnt <= cnt + 1'b1;
               if (tick) phase <= PH_IDLE;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   // R9: data phase is only entered when the line was low at mid-start
   p_confirm_low_r9: assert property (@(posedge clk) disable iff (rst)
      $rose(phase == PH_DATA) |-> $past(!rx_line));

   // R11: after the stop sample the receiver is back to looking for an edge
   p_rearm_r11: assert property (@(posedge clk) disable iff (rst)
      sample_stop |=> (phase == PH_IDLE));

   // R4: a frame without parity never reaches a parity sample
   p_skip_parity_r4: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_PAR) |-> !poff_q);

endmodule

// File: rtl/rx_char_assembler.sv
module rx_char_assembler
   import async_rx_pkg::*;
(
   input  logic                clk,
   input  logic                rst,
   input  logic                rx_line,
   input  logic                frame_start,
   input  logic                sample_data,
   input  logic                sample_par,
   input  logic [IDX_W-1:0]    bit_idx,
   output logic [CHAR_MAX-1:0] word,
   output logic                data_xor,
   output logic                par_bit
);

   logic [CHAR_MAX-1:0] word_nxt;

   // one capture slot per bit; a new frame clears every slot
   generate
      for (genvar i = 0; i < CHAR_MAX; i++) begin : g_slot
         assign word_nxt[i] = frame_start ? 1'b0 :
                              (sample_data && (bit_idx == IDX_W'(i))) ? rx_line :
                              word[i];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         word     <= '0;
         data_xor <= 1'b0;
         par_bit  <= 1'b0;
      end else begin
         word <= word_nxt;
         if (frame_start) begin
            data_xor <= 1'b0;
            par_bit  <= 1'b0;
         end else begin
            if (sample_data) data_xor <= data_xor ^ rx_line;
            if (sample_par)  par_bit  <= rx_line;
         end
      end
   end

   // R1: a fresh frame starts from an all-zero word
   p_clear_word_r1: assert property (@(posedge clk) disable iff (rst)
      frame_start |=> (word == '0));

endmodule

// File: rtl/rx_holding_reg.sv
module rx_holding_reg
   import async_rx_pkg::*;
(
   input  logic                clk,
   input  logic                rst,
   input  logic                load,
   input  logic                stop_val,
   input  logic [CHAR_MAX-1:0] word,
   input  logic                data_xor,
   input  logic                par_bit,
   input  logic                poff,
   input  logic                even,
   input  logic                clr_ready,
   output logic [CHAR_MAX-1:0] rx_data,
   output logic                data_ready,
   output logic                overrun_err,
   output logic                framing_err,
   output logic                parity_err
);

   logic par_bad;

   // even sense: data ones plus parity must be even, so xor must be 0
   assign par_bad = !poff && ((data_xor ^ par_bit) == even);

   always_ff @(posedge clk) begin
      if (rst) begin
         rx_data     <= '0;
         data_ready  <= 1'b0;
         overrun_err <= 1'b0;
         framing_err <= 1'b0;
         parity_err  <= 1'b0;
      end else if (load) begin
         rx_data     <= word;
         data_ready  <= 1'b1;
         overrun_err <= data_ready && !clr_ready;
         framing_err <= !stop_val;
         parity_err  <= par_bad;
      end else if (clr_ready) begin
         data_ready  <= 1'b0;
      end
   end

   p_load_ready_r6: assert property (@(posedge clk) disable iff (rst)
      load |=> data_ready);

   p_clear_ready_r7: assert property (@(posedge clk) disable iff (rst)
      (clr_ready && !load) |=> (!data_ready && $stable(rx_data)));

   p_overrun_r8: assert property (@(posedge clk) disable iff (rst)
      (load && data_ready && !clr_ready) |=> overrun_err);

   p_framing_r5: assert property (@(posedge clk) disable iff (rst)
      (load && !stop_val) |=> framing_err);

   p_no_parity_r4: assert property (@(posedge clk) disable iff (rst)
      (load && poff) |=> !parity_err);

   p_flags_hold_r12: assert property (@(posedge clk) disable iff (rst)
      !load |=> ($stable(overrun_err) && $stable(framing_err) && $stable(parity_err)));

endmodule

// File: rtl/async_char_rx.sv
module async_char_rx
   import async_rx_pkg::*;
#(
   parameter int OVERSAMPLE = 16
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       rx_line,
   input  logic [1:0] len_sel,
   input  logic       parity_off,
   input  logic       parity_even,
   input  logic       clr_ready,
   output logic [7:0] rx_data,
   output logic       data_ready,
   output logic       overrun_err,
   output logic       framing_err,
   output logic       parity_err
);

   logic             frame_start;
   logic             sample_data;
   logic             sample_par;
   logic             sample_stop;
   logic [IDX_W-1:0] bit_idx;
   logic [1:0]       len_q;
   logic             poff_q;
   logic             even_q;
   logic [CHAR_MAX-1:0] word;
   logic             data_xor;
   logic             par_bit;

   rx_bit_timer #(.OVERSAMPLE(OVERSAMPLE)) u_timer (
      .clk         (clk),
      .rst         (rst),
      .rx_line     (rx_line),
      .len_sel     (len_sel),
      .parity_off  (parity_off),
      .parity_even (parity_even),
      .frame_start (frame_start),
      .sample_data (sample_data),
      .sample_par  (sample_par),
      .sample_stop (sample_stop),
      .bit_idx     (bit_idx),
      .len_q       (len_q),
      .poff_q      (poff_q),
      .even_q      (even_q)
   );

   rx_char_assembler u_asm (
      .clk         (clk),
      .rst         (rst),
      .rx_line     (rx_line),
      .frame_start (frame_start),
      .sample_data (sample_data),
      .sample_par  (sample_par),
      .bit_idx     (bit_idx),
      .word        (word),
      .data_xor    (data_xor),
      .par_bit     (par_bit)
   );

   rx_holding_reg u_hold (
      .clk         (clk),
      .rst         (rst),
      .load        (sample_stop),
      .stop_val    (rx_line),
      .word        (word),
      .data_xor    (data_xor),
      .par_bit     (par_bit),
      .poff        (poff_q),
      .even        (even_q),
      .clr_ready   (clr_ready),
      .rx_data     (rx_data),
      .data_ready  (data_ready),
      .overrun_err (overrun_err),
      .framing_err (framing_err),
      .parity_err  (parity_err)
   );

   // R1: bits above the latched character length read as zero after a transfer
   p_upper_zero_r1: assert property (@(posedge clk) disable iff (rst)
      sample_stop |=> ((rx_data >> (4'd5 + {2'b00, $past(len_q)})) == 8'h00));

   // R10: reset leaves no pending character
   p_reset_clear_r10: assert property (@(posedge clk)
      $past(rst) |-> (!data_ready && !overrun_err && !framing_err && !parity_err));

endmodule

// File: tb/async_char_rx_test.sv
module async_char_rx_test;

   localparam int CLK_PERIOD = 10;
   localparam int OS         = 16;

   // {len[1:0], parity_off, parity_even, flip_parity, stop_bit, data[7:0]}
   localparam logic [13:0] VEC [8] = '{
      14'h35A5, 14'h01FF, 14'h193A, 14'h2755,
      14'h3396, 14'h3B81, 14'h040B, 14'h21C3
   };

   logic       clk = 1'b0;
   logic       rst;
   logic       rx_line;
   logic [1:0] len_sel;
   logic       parity_off;
   logic       parity_even;
   logic       clr_ready;
   logic [7:0] rx_data;
   logic       data_ready;
   logic       overrun_err;
   logic       framing_err;
   logic       parity_err;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   async_char_rx #(.OVERSAMPLE(OS)) uut (
      .clk         (clk),
      .rst         (rst),
      .rx_line     (rx_line),
      .len_sel     (len_sel),
      .parity_off  (parity_off),
      .parity_even (parity_even),
      .clr_ready   (clr_ready),
      .rx_data     (rx_data),
      .data_ready  (data_ready),
      .overrun_err (overrun_err),
      .framing_err (framing_err),
      .parity_err  (parity_err)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // drive one frame; returns just after the stop-bit sample edge
   task automatic send_frame(input logic [13:0] v, input int pre);
      int   nb;
      logic pb;
      len_sel     = v[13:12];
      parity_off  = v[11];
      parity_even = v[10];
      nb = 5 + int'(v[13:12]);
      repeat (pre) @(negedge clk);
      rx_line = 1'b0;
      repeat (OS) @(negedge clk);
      pb = 1'b0;
      for (int i = 0; i < nb; i++) begin
         rx_line = v[i];
         pb      = pb ^ v[i];
         repeat (OS) @(negedge clk);
      end
      if (!v[11]) begin
         rx_line = (v[10] ? pb : ~pb) ^ v[9];
         repeat (OS) @(negedge clk);
      end
      rx_line = v[8];
      repeat (OS / 2 + 1) @(negedge clk);
   endtask

   task automatic finish_stop();
      repeat (OS / 2 - 1) @(negedge clk);
      rx_line = 1'b1;
   endtask

   task automatic pulse_clear();
      clr_ready = 1'b1;
      @(negedge clk);
      clr_ready = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; rx_line = 1'b1; len_sel = 2'b11;
      parity_off = 1'b1; parity_even = 1'b0; clr_ready = 1'b0;
      repeat (4) @(negedge clk);
      // R10 reset state
      check("R10 ready", data_ready, 0);
      check("R10 data", rx_data, 0);
      check("R10 flags", {overrun_err, framing_err, parity_err}, 0);
      rst = 1'b0;
      repeat (3) @(negedge clk);

      // table walk: R1 R2 R3 R4 R5 R6 R7, R12 via entry 6 then 7
      for (int k = 0; k < 8; k++) begin
         logic [7:0] mask;
         mask = 8'((9'd1 << (5 + int'(VEC[k][13:12]))) - 1);
         send_frame(VEC[k], 3);
         check($sformatf("R1/R2 data v%0d", k), rx_data, VEC[k][7:0] & mask);
         check($sformatf("R6 ready v%0d", k), data_ready, 1);
         check($sformatf("R3/R4 parity v%0d", k), parity_err, !VEC[k][11] && VEC[k][9]);
         check($sformatf("R5/R12 framing v%0d", k), framing_err, !VEC[k][8]);
         check($sformatf("R8 no overrun v%0d", k), overrun_err, 0);
         finish_stop();
         pulse_clear();
         check($sformatf("R7 cleared v%0d", k), data_ready, 0);
         check($sformatf("R7 data kept v%0d", k), rx_data, VEC[k][7:0] & mask);
      end

      // R9: glitch shorter than half a bit
      rx_line = 1'b0;
      repeat (4) @(negedge clk);
      rx_line = 1'b1;
      repeat (40) @(negedge clk);
      check("R9 glitch ready", data_ready, 0);
      check("R9 glitch data", rx_data, 8'h43);

      // R8 overrun, then R12 cleared by the next collected character
      send_frame(14'h3911, 3); finish_stop();
      send_frame(14'h3922, 3);
      check("R8 overrun set", overrun_err, 1);
      check("R8 new data", rx_data, 8'h22);
      finish_stop();
      pulse_clear();
      send_frame(14'h3933, 3);
      check("R12 overrun rewritten", overrun_err, 0);
      check("R12 data", rx_data, 8'h33);
      finish_stop();
      pulse_clear();

      // R11: next start edge right after the stop sample
      send_frame(14'h395A, 3);
      check("R11 first", rx_data, 8'h5A);
      send_frame(14'h35A5, 0);
      check("R11 second data", rx_data, 8'hA5);
      check("R11 second parity", parity_err, 0);
      check("R11 second ready", data_ready, 1);
      finish_stop();

      // R10: reset in the middle of a frame
      rx_line = 1'b0;
      repeat (30) @(negedge clk);
      rst = 1'b1; rx_line = 1'b1;
      repeat (2) @(negedge clk);
      check("R10 mid-frame ready", data_ready, 0);
      check("R10 mid-frame flags", {overrun_err, framing_err, parity_err}, 0);
      check("R10 mid-frame data", rx_data, 0);
      rst = 1'b0;
      repeat (3) @(negedge clk);
      send_frame(14'h3D6C, 3);
      check("R10 recovery data", rx_data, 8'h6C);
      check("R10 recovery overrun", overrun_err, 0);
      finish_stop();

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule